// File: doc/BRIEF.md
# Split-Cycle Destructive-Read Memory Sequencer

This block drives a word memory that loses its contents when read. Each access runs as two timed phases. The read phase fetches the addressed word, hands it to the requester and then zeroes the location. The write phase that follows puts a word back into the location. A load writes back the word it just fetched, so memory appears unchanged. A store writes a new word supplied with the request. A replace holds the write phase open until the requester returns a computed result, which saves a second full memory cycle on read-modify-write.

The read data is registered and presented for one cycle at the end of the read phase. This lets the requester work on the word while the write phase is still running. Phase lengths are parameters counted in clock cycles. A request is taken only while the sequencer is idle. A one-cycle done pulse marks the end of every access.

Top module: `scm_ctrl`

## Requirements
- R1: After reset, `rd_valid_o` and `done_o` are low, `rd_data_o` is zero and the sequencer is idle.
- R2: `op_i` encodes 0 = load, 1 = store and 2 = replace. Code 3 behaves exactly like a load.
- R3: If a request is taken at clock edge E, `rd_valid_o` is high for exactly one cycle after edge E+RD_CYC. During that cycle `rd_data_o` holds the word stored at the address before the access, and the location is zeroed at that same edge.
- R4: A load writes the fetched word back, so a later load of the same address returns the same word.
- R5: A store returns the old word in its read phase, and a later load returns the word given on `wdata_i` with the request.
- R6: A replace enters a hold state after its read phase. It stays there with `done_o` low for as long as `res_valid_i` is low. At the first edge where `res_valid_i` is high, `wdata_i` is taken as the result. A later load returns that result.
- R7: `done_o` is high for exactly one cycle, after edge S+WR_CYC, where S is the edge that ends the read phase (load or store) or the edge that takes the result (replace).
- R8: A request that arrives while an access is in progress is ignored and does not change memory.
- R9: `res_valid_i` has no effect outside the hold state.
- R10: The full address range is usable, including address 0 and address 2^ADDR_W-1, with any 48-bit pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, taken only when idle |
| op_i | input | 2 | Access kind (0 load, 1 store, 2 replace, 3 load) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Store data with the request; replace result with `res_valid_i` |
| res_valid_i | input | 1 | Replace result present on `wdata_i` |
| rd_data_o | output | DATA_W | Word fetched in the read phase |
| rd_valid_o | output | 1 | One-cycle strobe qualifying `rd_data_o` |
| done_o | output | 1 | One-cycle strobe at the end of the write phase |

## Verification
Some properties are checked on every cycle. The location is zeroed at the edge that raises the read strobe. Both strobes last a single cycle. No memory write happens while a replace waits for its result. The latched address changes only when a request is taken, and an idle sequencer stays idle without a request. The scenarios cover what only data can show: restore after load, the new word after store, the delayed result after replace, the alias opcode, and the exact phase timing. They also show that requests and results arriving at the wrong time leave memory untouched.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD     = 2'd0,
    OP_STORE    = 2'd1,
    OP_REPLACE  = 2'd2,
    OP_LOAD_ALT = 2'd3
  } scm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_HOLD,
    ST_WRITE
  } scm_state_e;
endpackage

// File: rtl/scm_mem.sv
module scm_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // simple dual-port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/scm_seq.sv
module scm_seq
  import scm_pkg::*;
#(
  parameter int RD_CYC = 4,
  parameter int WR_CYC = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       hold_mode_i,
  input  logic       res_valid_i,
  output logic       accept_o,
  output logic       rd_end_o,
  output logic       hold_take_o,
  output logic       wr_end_o,
  output scm_state_e state_o
);
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);

  scm_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;

  assign accept_o    = (state_q == ST_IDLE) && req_i;
  assign rd_end_o    = (state_q == ST_READ) && (cnt_q == RD_LAST);
  assign hold_take_o = (state_q == ST_HOLD) && res_valid_i;
  assign wr_end_o    = (state_q == ST_WRITE) && (cnt_q == WR_LAST);
  assign state_o     = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q <= ST_READ;
          cnt_q   <= '0;
          hold_q  <= hold_mode_i;
        end
        ST_READ: begin
          if (rd_end_o) begin
            state_q <= hold_q ? ST_HOLD : ST_WRITE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: if (hold_take_o) begin
          state_q <= ST_WRITE;
          cnt_q   <= '0;
        end
        ST_WRITE: begin
          if (wr_end_o) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !req_i) |=> (state_q == ST_IDLE));

  // R6
  hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && !res_valid_i) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/scm_ctrl.sv
module scm_ctrl
  import scm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 48,
  parameter int RD_CYC = 4,
  parameter int WR_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              res_valid_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o
);
  scm_state_e        state;
  logic              accept, rd_end, hold_take, wr_end;
  logic [ADDR_W-1:0] addr_q;
  scm_op_e           op_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic              op_restores;

  scm_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .hold_mode_i (scm_op_e'(op_i) == OP_REPLACE),
    .res_valid_i (res_valid_i),
    .accept_o    (accept),
    .rd_end_o    (rd_end),
    .hold_take_o (hold_take),
    .wr_end_o    (wr_end),
    .state_o     (state)
  );

  assign op_restores = (op_q == OP_LOAD) || (op_q == OP_LOAD_ALT);

  // read phase ends by zeroing; write phase ends with restore or new word
  always_comb begin
    mem_we    = rd_end || wr_end;
    mem_wdata = '0;
    if (wr_end) mem_wdata = op_restores ? rd_data_o : data_q;
  end

  scm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_q),
    .wdata (mem_wdata),
    .raddr (addr_q),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      op_q       <= OP_LOAD;
      data_q     <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= addr_i;
        op_q   <= scm_op_e'(op_i);
        data_q <= wdata_i;
      end
      if (hold_take) data_q <= wdata_i;
      if (rd_end) rd_data_o <= mem_rdata;
      rd_valid_o <= rd_end;
      done_o     <= wr_end;
    end
  end

  // R3
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> ($past(mem_we) && $past(mem_wdata) == '0));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |=> !rd_valid_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> !mem_we);

  // R8
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(addr_q));
endmodule

// File: tb/scm_ctrl_tb_top.sv
module scm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 48;
  localparam int RD_CYC = 4;
  localparam int WR_CYC = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_i;
  logic [1:0]        op_i;
  logic [ADDR_W-1:0] addr_i;
  logic [DATA_W-1:0] wdata_i;
  logic              res_valid_i;
  logic [DATA_W-1:0] rd_data_o;
  logic              rd_valid_o;
  logic              done_o;

  int errors = 0;
  int checks = 0;
  logic [DATA_W-1:0] ref_m [int];
  logic [DATA_W:0]   exp_q [$];
  bit                finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .res_valid_i(res_valid_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected read words as the strobe appears
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected read strobe", 1, 0);
      end else begin
        logic [DATA_W:0] e;
        e = exp_q.pop_front();
        if (e[DATA_W]) check("R3 read word", rd_data_o, e[DATA_W-1:0]);
      end
    end
  end

  // driver: one full access with phase-timing checks
  task automatic access(input logic [1:0] op, input int addr, input logic [DATA_W-1:0] data,
                        input int hold, input bit inject, input int inj_addr);
    logic [DATA_W-1:0] newv;
    bit known;
    known = ref_m.exists(addr);
    @(negedge clk);
    req_i = 1; op_i = op; addr_i = ADDR_W'(addr); wdata_i = data;
    @(posedge clk);
    @(negedge clk);
    exp_q.push_back({known, known ? ref_m[addr] : '0});
    if (inject) begin
      req_i = 1; op_i = 2'd1; addr_i = ADDR_W'(inj_addr); wdata_i = '1;
    end else req_i = 0;
    @(posedge clk);
    @(negedge clk);
    req_i = 0;
    repeat (RD_CYC-2) @(posedge clk);
    @(negedge clk);
    check("R3 read strobe not yet", rd_valid_o, 0);
    @(posedge clk);
    @(negedge clk);
    check("R3 read strobe timing", rd_valid_o, 1);
    newv = (op == 2'd1 || op == 2'd2) ? data : ref_m[addr];
    if (op == 2'd2) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        check("R6 done low while holding", done_o, 0);
      end
      res_valid_i = 1; wdata_i = data;
      @(posedge clk);
      @(negedge clk);
      res_valid_i = 0; wdata_i = ~data;
    end
    repeat (WR_CYC-1) @(posedge clk);
    @(negedge clk);
    check("R7 done not early", done_o, 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 done timing", done_o, 1);
    @(negedge clk);
    check("R7 done single cycle", done_o, 0);
    ref_m[addr] = newv;
  endtask

  initial begin
    rst = 1; req_i = 0; op_i = 0; addr_i = '0; wdata_i = '0; res_valid_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 rd_valid reset", rd_valid_o, 0);
    check("R1 done reset", done_o, 0);
    check("R1 rd_data reset", rd_data_o, '0);
    rst = 0;

    access(2'd1, 5, 48'h1234_5678_9ABC, 0, 0, 0);   // R5 first store
    access(2'd0, 5, '0, 0, 0, 0);                   // R4 load restores
    access(2'd0, 5, '0, 0, 0, 0);                   // R4 second load same word
    access(2'd1, 5, 48'hDEAD_BEEF_0001, 0, 0, 0);   // R5 store returns old
    access(2'd0, 5, '0, 0, 0, 0);                   // R5 new word visible
    access(2'd2, 5, 48'h0F0F_F0F0_5A5A, 5, 0, 0);   // R6 replace, held 5 cycles
    access(2'd0, 5, '0, 0, 0, 0);                   // R6 result visible
    access(2'd2, 5, 48'h0000_0000_0007, 0, 0, 0);   // R6 replace, immediate result
    access(2'd3, 5, '0, 0, 0, 0);                   // R2 code 3 acts as load
    access(2'd0, 5, '0, 0, 0, 0);                   // R2 code 3 restored word
    access(2'd1, 9, 48'hAAAA_5555_AAAA, 0, 0, 0);
    access(2'd0, 5, '0, 0, 1, 9);                   // R8 request during read phase
    access(2'd0, 9, '0, 0, 0, 0);                   // R8 address 9 untouched

    // R9: result strobes while idle do nothing
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      res_valid_i = 1; wdata_i = 48'hBAD0_BAD0_BAD0;
      @(negedge clk);
      check("R9 idle result no done", done_o, 0);
      check("R9 idle result no read", rd_valid_o, 0);
    end
    res_valid_i = 0;
    access(2'd0, 5, '0, 0, 0, 0);                   // R9 memory unchanged

    access(2'd1, 0, 48'hFFFF_FFFF_FFFF, 0, 0, 0);   // R10 lowest address
    access(2'd1, 4095, 48'h8000_0000_0001, 0, 0, 0);// R10 highest address
    access(2'd0, 0, '0, 0, 0, 0);                   // R10
    access(2'd0, 4095, '0, 0, 0, 0);                // R10

    repeat (3) @(negedge clk);
    check("R3 all reads observed", 48'(exp_q.size()), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule